// File: doc/BRIEF.md
# USB Low/Full-Speed Receive Symbol Framer

This block takes the two USB data lines, already brought into a system clock domain that runs faster than the bit rate, and turns them into a stream of per-bit symbols for a downstream decoder. On every clock it classifies the line pair as J, K, SE0 or SE1. In the J and K mapping, the two speeds use opposite polarities. While the line is idle, the first K marks the start of a packet. That clock edge is the fixed reference for timing the rest of the packet. Every later bit is sampled at its nominal centre, counted from this reference, and the sample point does not follow transitions.

Inside a packet, each bit-centre J or K goes out as a one-clock symbol strobe. A bit-centre SE0 starts the end-of-packet phase. Bit-centre sampling continues until an SE0 is followed directly by a J. The block then issues an end pulse and returns to idle. A packet-active flag covers the whole frame. An SE1 seen at a bit centre sets a sticky error flag. A static input selects low speed (32 clocks per bit) or full speed (4 clocks per bit).

Top module: `usb_rx_framer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, sop_o, eop_o, active_o, sym_valid_o and se1_err_o are 0 and sym_o is 2'b01. Reset is asynchronous and active low.
- R2: With low_speed_i=0, (dp,dm)=(1,0) is reported as J (code 2'b01) and (0,1) as K (code 2'b10). SE0 is (0,0) with code 2'b00, and SE1 is (1,1) with code 2'b11.
- R3: With low_speed_i=1, the J and K mapping is swapped: (0,1) is J (2'b01) and (1,0) is K (2'b10). SE0 and SE1 are unchanged.
- R4: In idle, the first clock edge that samples K raises sop_o for exactly one cycle after that edge. J, SE0 and SE1 in idle raise nothing.
- R5: If E0 is the edge that took the start K, bit n is sampled at edge E0 + P/2 + n*P, where P is 4 at full speed and 32 at low speed. A J or K there gives a one-cycle sym_valid_o with sym_o equal to that symbol. No strobe occurs at any other edge.
- R6: SE0 and SE1 at a bit centre produce no strobe. SE0 at a bit centre of a data bit starts the end-of-packet phase.
- R7: In the end-of-packet phase, eop_o pulses for one cycle when a bit-centre J directly follows a bit-centre SE0, and the block returns to idle. A J that follows any other symbol, for example SE0, K, J, does not end the packet. The closing J is never strobed.
- R8: active_o rises in the cycle of sop_o, stays high through the cycle of eop_o, and is low in the cycle after.
- R9: An SE1 at a bit centre inside a packet sets se1_err_o. Only reset clears it, and the SE1 does not change the phase of the packet.
- R10: Line values between bit centres have no effect inside a packet, including SE0 or the opposite data state held for every off-centre cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, four times the full-speed bit rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| low_speed_i | input | 1 | Static speed select: 1 = low speed, 0 = full speed |
| dp_i | input | 1 | Positive data line, already synchronous to clk_i |
| dm_i | input | 1 | Negative data line, already synchronous to clk_i |
| sop_o | output | 1 | One-cycle start-of-packet pulse |
| eop_o | output | 1 | One-cycle end-of-packet pulse |
| active_o | output | 1 | High from start through end of a packet |
| sym_valid_o | output | 1 | One-cycle strobe for each data symbol |
| sym_o | output | 2 | Symbol code of the latest strobe (01 J, 10 K) |
| se1_err_o | output | 1 | Sticky flag: SE1 seen at a bit centre |

## Verification
The same frame script is replayed in both speeds, with the line pair driven through the speed-specific mapping. A swapped or ignored polarity therefore shows up as a missing start or wrong symbol codes, and a wrong period shows up as strobes on the wrong cycle. Some bits hold SE0 or the opposite data state on every off-centre cycle, which separates true centre sampling from edge tracking or majority logic. The end phase is tried with SE0-K-J before a real SE0-J, so a design that closes on any J is caught. SE0 and SE1 are driven in idle, and a reset is applied in the middle of a frame.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_sym_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_BIT  = 2'b01,
        ST_EOP  = 2'b10
    } frm_state_e;

    typedef struct packed {
        frm_state_e state;
        line_sym_e  last_sym;
        line_sym_e  sym;
        logic       sop;
        logic       eop;
        logic       active;
        logic       sym_vld;
        logic       se1_err;
    } frm_regs_t;

    localparam frm_regs_t FRM_RST = '{
        state:    ST_IDLE,
        last_sym: LS_J,
        sym:      LS_J,
        sop:      1'b0,
        eop:      1'b0,
        active:   1'b0,
        sym_vld:  1'b0,
        se1_err:  1'b0
    };

endpackage

// File: rtl/usb_line_decode.sv
module usb_line_decode
    import usb_rx_pkg::*;
(
    input  logic      low_speed_i,
    input  logic      dp_i,
    input  logic      dm_i,
    output line_sym_e sym_o
);

    // J/K polarity flips between the two speed modes; SE0/SE1 do not
    always_comb begin
        unique case ({dp_i, dm_i})
            2'b00:   sym_o = LS_SE0;
            2'b11:   sym_o = LS_SE1;
            2'b10:   sym_o = low_speed_i ? LS_K : LS_J;
            default: sym_o = low_speed_i ? LS_J : LS_K;
        endcase
    end

endmodule

// File: rtl/usb_bit_timer.sv
module usb_bit_timer #(
    parameter int unsigned CLKS_FS_BIT = 4,
    parameter int unsigned CLKS_LS_BIT = 32
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic low_speed_i,
    input  logic start_i,
    input  logic run_i,
    output logic tick_o
);

    localparam int unsigned MAX_BIT = (CLKS_LS_BIT > CLKS_FS_BIT) ? CLKS_LS_BIT : CLKS_FS_BIT;
    localparam int unsigned CNT_W   = $clog2(MAX_BIT + 1);

    localparam logic [CNT_W-1:0] FS_HALF_M1 = CNT_W'(CLKS_FS_BIT / 2 - 1);
    localparam logic [CNT_W-1:0] LS_HALF_M1 = CNT_W'(CLKS_LS_BIT / 2 - 1);
    localparam logic [CNT_W-1:0] FS_FULL_M1 = CNT_W'(CLKS_FS_BIT - 1);
    localparam logic [CNT_W-1:0] LS_FULL_M1 = CNT_W'(CLKS_LS_BIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] half_m1, full_m1;

    assign half_m1 = low_speed_i ? LS_HALF_M1 : FS_HALF_M1;
    assign full_m1 = low_speed_i ? LS_FULL_M1 : FS_FULL_M1;

    // Countdown to the next bit centre; every target is a fixed offset
    // from the start edge, so no transition ever moves it
    always_comb begin
        cnt_d  = cnt_q;
        tick_o = run_i && (cnt_q == '0);
        if (start_i) begin
            cnt_d = half_m1;
        end else if (run_i) begin
            cnt_d = (cnt_q == '0) ? full_m1 : cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/usb_rx_framer.sv
module usb_rx_framer
    import usb_rx_pkg::*;
#(
    parameter int unsigned CLKS_FS_BIT = 4,
    parameter int unsigned CLKS_LS_BIT = 32
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       low_speed_i,
    input  logic       dp_i,
    input  logic       dm_i,
    output logic       sop_o,
    output logic       eop_o,
    output logic       active_o,
    output logic       sym_valid_o,
    output logic [1:0] sym_o,
    output logic       se1_err_o
);

    line_sym_e cur_sym;
    logic      tmr_start;
    logic      tmr_run;
    logic      tick;
    frm_regs_t r_d, r_q;

    usb_line_decode u_decode (
        .low_speed_i (low_speed_i),
        .dp_i        (dp_i),
        .dm_i        (dm_i),
        .sym_o       (cur_sym)
    );

    assign tmr_run = (r_q.state != ST_IDLE);

    usb_bit_timer #(
        .CLKS_FS_BIT (CLKS_FS_BIT),
        .CLKS_LS_BIT (CLKS_LS_BIT)
    ) u_timer (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .low_speed_i (low_speed_i),
        .start_i     (tmr_start),
        .run_i       (tmr_run),
        .tick_o      (tick)
    );

    always_comb begin
        r_d         = r_q;
        r_d.sop     = 1'b0;
        r_d.eop     = 1'b0;
        r_d.sym_vld = 1'b0;
        tmr_start   = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (cur_sym == LS_K) begin
                    r_d.state = ST_BIT;
                    r_d.sop   = 1'b1;
                    tmr_start = 1'b1;
                end
            end
            ST_BIT: begin
                if (tick) begin
                    r_d.last_sym = cur_sym;
                    unique case (cur_sym)
                        LS_J, LS_K: begin
                            r_d.sym_vld = 1'b1;
                            r_d.sym     = cur_sym;
                        end
                        LS_SE0:  r_d.state   = ST_EOP;
                        default: r_d.se1_err = 1'b1;
                    endcase
                end
            end
            ST_EOP: begin
                if (tick) begin
                    r_d.last_sym = cur_sym;
                    if (cur_sym == LS_SE1) begin
                        r_d.se1_err = 1'b1;
                    end
                    if (cur_sym == LS_J && r_q.last_sym == LS_SE0) begin
                        r_d.eop      = 1'b1;
                        r_d.state    = ST_IDLE;
                        r_d.last_sym = LS_J;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        r_d.active = (r_d.state != ST_IDLE) || r_d.eop;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= FRM_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign sop_o       = r_q.sop;
    assign eop_o       = r_q.eop;
    assign active_o    = r_q.active;
    assign sym_valid_o = r_q.sym_vld;
    assign sym_o       = r_q.sym;
    assign se1_err_o   = r_q.se1_err;

endmodule

// File: rtl/usb_rx_framer_chk.sv
module usb_rx_framer_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       sop_o,
    input logic       eop_o,
    input logic       active_o,
    input logic       sym_valid_o,
    input logic [1:0] sym_o,
    input logic       se1_err_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (!sop_o && !eop_o && !active_o && !sym_valid_o && !se1_err_o));

    // R4
    sop_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sop_o |-> active_o);

    // R4
    sop_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sop_o |=> !sop_o);

    // R8
    rise_needs_sop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(active_o) |-> sop_o);

    // R8
    eop_in_pkt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eop_o |-> active_o);

    // R8
    eop_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eop_o |=> !active_o);

    // R6
    data_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sym_valid_o |-> (sym_o == 2'b01 || sym_o == 2'b10));

    // R5
    no_strobe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !active_o |-> !sym_valid_o);

    // R9
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        se1_err_o |=> se1_err_o);

endmodule

bind usb_rx_framer usb_rx_framer_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sop_o       (sop_o),
    .eop_o       (eop_o),
    .active_o    (active_o),
    .sym_valid_o (sym_valid_o),
    .sym_o       (sym_o),
    .se1_err_o   (se1_err_o)
);

// File: tb/usb_rx_framer_tb.sv
module usb_rx_framer_tb;

    localparam bit [1:0] S0 = 2'd0;
    localparam bit [1:0] SJ = 2'd1;
    localparam bit [1:0] SK = 2'd2;
    localparam bit [1:0] S1 = 2'd3;
    localparam int NV = 18;

    // {sop, eop, vld, centre symbol, off-centre symbol}
    localparam logic [6:0] VEC [NV] = '{
        {3'b101, SK, SK},
        {3'b001, SJ, S0},
        {3'b001, SK, SJ},
        {3'b001, SK, SK},
        {3'b000, S1, S1},
        {3'b001, SJ, SJ},
        {3'b000, S0, S0},
        {3'b000, SK, SK},
        {3'b000, SJ, SJ},
        {3'b000, S0, S0},
        {3'b010, SJ, SJ},
        {3'b000, SJ, SJ},
        {3'b000, S0, S0},
        {3'b000, S1, S1},
        {3'b101, SK, SK},
        {3'b000, S0, S0},
        {3'b010, SJ, SJ},
        {3'b000, SJ, SJ}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       low_speed = 1'b0;
    logic       dp = 1'b1;
    logic       dm = 1'b0;
    logic       sop, eop, active, sym_valid, se1_err;
    logic [1:0] sym;

    int n_chk = 0;
    int n_bad = 0;
    logic act_exp = 1'b0;
    logic err_exp = 1'b0;

    always #5 clk = ~clk;

    usb_rx_framer u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .low_speed_i (low_speed),
        .dp_i        (dp),
        .dm_i        (dm),
        .sop_o       (sop),
        .eop_o       (eop),
        .active_o    (active),
        .sym_valid_o (sym_valid),
        .sym_o       (sym),
        .se1_err_o   (se1_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Maps a symbol code onto the line pair for the selected speed (R2, R3)
    task automatic set_line(input logic [1:0] s, input logic ls);
        case (s)
            S0: begin dp = 1'b0; dm = 1'b0; end
            S1: begin dp = 1'b1; dm = 1'b1; end
            SJ: begin dp = ls ? 1'b0 : 1'b1; dm = ls ? 1'b1 : 1'b0; end
            default: begin dp = ls ? 1'b1 : 1'b0; dm = ls ? 1'b0 : 1'b1; end
        endcase
    endtask

    task automatic run_table(input logic ls);
        int per;
        per = ls ? 32 : 4;
        for (int k = 0; k < NV; k++) begin
            logic       e_sop, e_eop, e_vld;
            logic [1:0] ctr, off;
            e_sop = VEC[k][6];
            e_eop = VEC[k][5];
            e_vld = VEC[k][4];
            ctr   = VEC[k][3:2];
            off   = VEC[k][1:0];
            for (int i = 0; i < per; i++) begin
                @(negedge clk);
                set_line((i == per / 2) ? ctr : off, ls);
                @(posedge clk);
                #1;
                if (i == 0 && e_sop) act_exp = 1'b1;
                chk("R4 sop", int'(sop), (i == 0) ? int'(e_sop) : 0);
                if (i == per / 2) begin
                    if (ctr == S1 && act_exp) err_exp = 1'b1;
                    chk((ctr == SJ || ctr == SK) ? "R5 strobe" : "R6 no strobe",
                        int'(sym_valid), int'(e_vld));
                    if (e_vld)
                        chk((off != ctr) ? "R10 symbol" : (ls ? "R3 symbol" : "R2 symbol"),
                            int'(sym), int'(ctr));
                    chk("R7 eop", int'(eop), int'(e_eop));
                end else begin
                    chk("R5 off-centre", int'(sym_valid), 0);
                    chk("R7 off-centre", int'(eop), 0);
                end
                chk("R8 active", int'(active), int'(act_exp));
                chk("R9 err", int'(se1_err), int'(err_exp));
                if (i == per / 2 && e_eop) act_exp = 1'b0;
            end
        end
    endtask

    task automatic chk_reset_state();
        chk("R1 sop", int'(sop), 0);
        chk("R1 eop", int'(eop), 0);
        chk("R1 active", int'(active), 0);
        chk("R1 strobe", int'(sym_valid), 0);
        chk("R1 sym", int'(sym), 1);
        chk("R1 err", int'(se1_err), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        set_line(SJ, 1'b0);
        repeat (3) @(posedge clk);
        #1;
        chk_reset_state();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk_reset_state();

        // Full speed frame script
        run_table(1'b0);
        repeat (5) @(posedge clk);
        #1;
        chk("R9 sticky idle", int'(se1_err), 1);

        // Reset in the middle of a frame
        @(negedge clk);
        set_line(SK, 1'b0);
        @(posedge clk);
        #1;
        chk("R4 directed sop", int'(sop), 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk_reset_state();
        act_exp   = 1'b0;
        err_exp   = 1'b0;
        low_speed = 1'b1;
        set_line(SJ, 1'b1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Low speed frame script
        run_table(1'b1);
        repeat (5) @(posedge clk);
        #1;
        chk("R9 sticky low speed", int'(se1_err), 1);
        chk("R8 idle after frame", int'(active), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule